// File: doc/BRIEF.md
# Format-Programmable Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It times itself from an external enable tick that runs at sixteen times the bit rate. A 3-bit format code selects the frame shape: 7 or 8 data bits, even, odd or no parity, and one or two stop bits. The code is sampled when a start bit is accepted, so a change in the middle of a frame takes effect only on the next frame.

Each completed character is loaded into a receive buffer, and a ready flag is raised. Three error flags report the most recent character: a stop bit received low, a parity mismatch, and a character that arrived while the previous one was still unread. A one-cycle read strobe from the host clears the ready flag and all three error flags. The buffer keeps its contents until the next character arrives.

Top module: `uart_frame_rx`

## Requirements
- R1: Format code `fmt_i` with bit 2 = 0 selects 7 data bits with parity (bit 0: 0 = even, 1 = odd) and two stop bits when bit 1 = 0, one stop bit when bit 1 = 1. Codes 100 and 101 select 8 data bits with no parity and two or one stop bits. Codes 110 and 111 select 8 data bits with even or odd parity and one stop bit. Data bits arrive LSB first.
- R2: When a character completes, `rdy_o` goes to 1 and `data_o` holds the character. In 7-bit formats `data_o[7]` is 0.
- R3: A one-cycle `rd_i` pulse with no character completing clears `rdy_o`, `ferr_o`, `oerr_o` and `perr_o`, and leaves `data_o` unchanged.
- R4: `oerr_o` is set when a character completes while `rdy_o` is 1, and is cleared when a character completes while `rdy_o` is 0.
- R5: `ferr_o` is set for a character if any of its stop bits is sampled low.
- R6: `perr_o` is set for a character whose parity bit does not give the selected even or odd parity over the data bits. It is always 0 in no-parity formats.
- R7: A low line that is no longer low at the middle of the start bit (8 ticks in) is discarded with no effect on the outputs. After a frame ends on a low line, no new frame starts until the line has been seen high.
- R8: `fmt_i` is captured when the start bit is detected, and a change during the frame does not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling enable, 16 per bit |
| rx_i | input | 1 | Serial line, idle high |
| fmt_i | input | 3 | Frame format code |
| rd_i | input | 1 | Host read strobe, one cycle |
| data_o | output | 8 | Last received character |
| rdy_o | output | 1 | Character waiting |
| ferr_o | output | 1 | Stop bit low |
| oerr_o | output | 1 | Character overwritten while unread |
| perr_o | output | 1 | Parity mismatch |

## Verification
A bit counter or tick phase that goes wrong moves the sampling point. This shows up as a wrong `data_o` or a false `ferr_o` one cycle after the last stop bit is sampled, in the same frame. A format that is captured or decoded wrongly shifts the frame length by one or two bits, so the error shows up as stop or parity bits read from the wrong position. Stale or sticky status state shows up as a flag that is still high the cycle after a read strobe. A start detector that does not rearm after a break shows up as a spurious extra character with `oerr_o` set.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef struct packed {
    logic eight;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } rx_fmt_t;

  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP} rx_state_e;

  function automatic rx_fmt_t fmt_decode(input logic [2:0] code);
    rx_fmt_t f;
    f.eight = code[2];
    if (!code[2]) begin
      f.par_en   = 1'b1;
      f.par_odd  = code[0];
      f.two_stop = ~code[1];
    end else begin
      f.par_en   = code[1];
      f.par_odd  = code[0];
      f.two_stop = ~code[1] & ~code[0];
    end
    return f;
  endfunction
endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '1;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic [2:0]    fmt_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          ferr_o,
  output logic          perr_o
);
  localparam int CW   = $clog2(OVS);
  localparam int IW   = $clog2(DW);
  localparam int HALF = OVS / 2;

  rx_state_e        st_q;
  logic [CW-1:0]    cnt_q;
  logic [IW-1:0]    idx_q;
  logic             stop_idx_q;
  logic             armed_q;
  rx_fmt_t          cfg_q;
  logic [DW-1:0]    shreg_q;
  logic             ferr_q, perr_q, done_q;
  logic             sample;
  logic [IW-1:0]    last_idx;

  assign sample   = tick_i && (cnt_q == CW'(OVS-1));
  assign last_idx = cfg_q.eight ? IW'(DW-1) : IW'(DW-2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      idx_q      <= '0;
      stop_idx_q <= 1'b0;
      armed_q    <= 1'b0;
      cfg_q      <= '0;
      shreg_q    <= '0;
      ferr_q     <= 1'b0;
      perr_q     <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (tick_i) begin
          if (line_i) armed_q <= 1'b1;
          else if (armed_q) begin
            st_q       <= ST_START;
            cnt_q      <= '0;
            idx_q      <= '0;
            stop_idx_q <= 1'b0;
            cfg_q      <= fmt_decode(fmt_i);
            shreg_q    <= '0;
            ferr_q     <= 1'b0;
            perr_q     <= 1'b0;
          end
        end
        ST_START: if (tick_i) begin
          if (cnt_q == CW'(HALF-1)) begin
            cnt_q <= '0;
            st_q  <= line_i ? ST_IDLE : ST_DATA;  // glitch rejection
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_DATA: if (tick_i) begin
          if (sample) begin
            cnt_q          <= '0;
            shreg_q[idx_q] <= line_i;
            idx_q          <= idx_q + 1'b1;
            if (idx_q == last_idx) st_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_PAR: if (tick_i) begin
          if (sample) begin
            cnt_q  <= '0;
            perr_q <= (^shreg_q) ^ line_i ^ cfg_q.par_odd;
            st_q   <= ST_STOP;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_STOP: if (tick_i) begin
          if (sample) begin
            cnt_q <= '0;
            if (!line_i) ferr_q <= 1'b1;
            if (stop_idx_q == cfg_q.two_stop) begin
              done_q  <= 1'b1;
              st_q    <= ST_IDLE;
              armed_q <= line_i;
            end else stop_idx_q <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;
  assign data_o = shreg_q;
  assign ferr_o = ferr_q;
  assign perr_o = perr_q;

  // R7: data phase only after a low line at mid start bit
  a_r7_start_confirmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DATA && $past(st_q) == ST_START) |-> !$past(line_i));

  // R1: in 7-bit formats bit 7 is never written
  a_r1_short_msb_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !cfg_q.eight) |-> !shreg_q[DW-1]);
endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          done_i,
  input  logic [DW-1:0] data_i,
  input  logic          ferr_i,
  input  logic          perr_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o,
  output logic          ferr_o,
  output logic          oerr_o,
  output logic          perr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      rdy_o  <= 1'b0;
      ferr_o <= 1'b0;
      oerr_o <= 1'b0;
      perr_o <= 1'b0;
    end else if (done_i) begin
      data_o <= data_i;
      rdy_o  <= 1'b1;
      ferr_o <= ferr_i;
      perr_o <= perr_i;
      oerr_o <= rdy_o & ~rd_i;
    end else if (rd_i) begin
      rdy_o  <= 1'b0;
      ferr_o <= 1'b0;
      oerr_o <= 1'b0;
      perr_o <= 1'b0;
    end
  end

  a_r2_rdy_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> rdy_o);

  a_r3_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !done_i) |=> (!rdy_o && !ferr_o && !oerr_o && !perr_o && $stable(data_o)));

  a_r4_overrun_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rdy_o && !rd_i) |=> oerr_o);

  a_r4_overrun_implies_rdy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oerr_o |-> rdy_o);
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx #(
  parameter int OVS      = 16,
  parameter int DW       = 8,
  parameter int SYNC_STG = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic [2:0]    fmt_i,
  input  logic          rd_i,
  output logic [DW-1:0] data_o,
  output logic          rdy_o,
  output logic          ferr_o,
  output logic          oerr_o,
  output logic          perr_o
);
  logic          line_s;
  logic          done;
  logic [DW-1:0] frame_data;
  logic          frame_ferr, frame_perr;

  uart_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(rx_i), .q_o(line_s)
  );

  uart_rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .line_i(line_s),
    .fmt_i(fmt_i), .done_o(done), .data_o(frame_data),
    .ferr_o(frame_ferr), .perr_o(frame_perr)
  );

  uart_rx_status #(.DW(DW)) u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .data_i(frame_data),
    .ferr_i(frame_ferr), .perr_i(frame_perr), .rd_i(rd_i),
    .data_o(data_o), .rdy_o(rdy_o), .ferr_o(ferr_o),
    .oerr_o(oerr_o), .perr_o(perr_o)
  );
endmodule

// File: tb/sim_uart_frame_rx.sv
`timescale 1ns/1ps
module sim_uart_frame_rx;
  localparam int OVS  = 16;
  localparam int TDIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       rx = 1'b1;
  logic [2:0] fmt = 3'd5;
  logic       rd = 1'b0;
  logic [7:0] data;
  logic       rdy, ferr, oerr, perr;

  int checks = 0, errors = 0;
  bit busy = 1'b1, done_flag = 1'b0;

  logic [7:0] m_data = 8'h00;
  bit m_rdy = 0, m_ferr = 0, m_oerr = 0, m_perr = 0;

  always #2 clk = ~clk;

  uart_frame_rx u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rx_i(rx), .fmt_i(fmt),
    .rd_i(rd), .data_o(data), .rdy_o(rdy), .ferr_o(ferr),
    .oerr_o(oerr), .perr_o(perr)
  );

  initial begin
    forever begin
      repeat (TDIV - 1) begin @(posedge clk); #1 tick = 1'b0; end
      @(posedge clk); #1 tick = 1'b1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // every-clock comparison against the model while outputs are settled
  always @(negedge clk) begin
    if (rst_n && !busy && !done_flag) begin
      chk(data == m_data, "R2 data", data, m_data);
      chk(rdy  == m_rdy,  "R2 rdy",  rdy,  m_rdy);
      chk(ferr == m_ferr, "R5 ferr", ferr, m_ferr);
      chk(oerr == m_oerr, "R4 oerr", oerr, m_oerr);
      chk(perr == m_perr, "R6 perr", perr, m_perr);
    end
  end

  task automatic hold_bit(input logic v, input int ticks);
    rx = v;
    repeat (ticks * TDIV) @(posedge clk);
    #1;
  endtask

  // send one frame; bad_stop bit k forces stop k low; fmt_late changes fmt after start
  task automatic send(input logic [2:0] code, input logic [7:0] d, input bit bad_par,
                      input logic [1:0] bad_stop, input int low_hold, input logic [2:0] fmt_late);
    bit eight, pen, podd, two;
    int nb;
    logic pbit;
    logic [7:0] dm;
    busy  = 1'b1;
    eight = code[2];
    pen   = code[2] ? code[1] : 1'b1;
    podd  = code[0];
    two   = code[2] ? (code[1:0] == 2'b00) : !code[1];
    nb    = eight ? 8 : 7;
    dm    = eight ? d : {1'b0, d[6:0]};
    fmt   = code;
    hold_bit(1'b0, OVS);
    fmt   = fmt_late;
    for (int i = 0; i < nb; i++) hold_bit(d[i], OVS);
    pbit = (^dm) ^ podd ^ bad_par;
    if (pen) hold_bit(pbit, OVS);
    hold_bit(!bad_stop[0], OVS);
    if (two) hold_bit(!bad_stop[1], OVS);
    if (low_hold > 0) hold_bit(1'b0, low_hold);
    hold_bit(1'b1, 2 * OVS);
    m_oerr = m_rdy;
    m_rdy  = 1;
    m_data = dm;
    m_ferr = (bad_stop[0] != 0) || (two && bad_stop[1] != 0);
    m_perr = pen && bad_par;
    busy   = 1'b0;
  endtask

  task automatic do_read;
    busy = 1'b1;
    rd = 1'b1;
    @(posedge clk); #1;
    rd = 1'b0;
    m_rdy = 0; m_ferr = 0; m_oerr = 0; m_perr = 0;
    busy = 1'b0;
    @(negedge clk);
    chk(!rdy && !ferr && !oerr && !perr, "R3 clear", {rdy, ferr, oerr, perr}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!rdy && !ferr && !oerr && !perr && data == 8'h00, "R2 reset", {rdy, ferr, oerr, perr}, 0);
    rst_n = 1'b1;
    repeat (4 * TDIV * OVS) @(posedge clk);
    #1 busy = 1'b0;

    // R1 every format, R6 parity good
    send(3'd5, 8'hA5, 0, 2'b00, 0, 3'd5); do_read();
    send(3'd4, 8'h3C, 0, 2'b00, 0, 3'd4); do_read();
    send(3'd6, 8'h81, 0, 2'b00, 0, 3'd6); do_read();
    send(3'd7, 8'h7E, 0, 2'b00, 0, 3'd7); do_read();
    send(3'd0, 8'hD5, 0, 2'b00, 0, 3'd0);
    chk(data[7] == 1'b0, "R2 msb7", data[7], 0); do_read();
    send(3'd1, 8'h2B, 0, 2'b00, 0, 3'd1); do_read();
    send(3'd2, 8'h40, 0, 2'b00, 0, 3'd2); do_read();
    send(3'd3, 8'h7F, 0, 2'b00, 0, 3'd3); do_read();

    // R6 parity errors
    send(3'd6, 8'h5A, 1, 2'b00, 0, 3'd6);
    chk(perr, "R6 perr even", perr, 1); do_read();
    send(3'd3, 8'h11, 1, 2'b00, 0, 3'd3);
    chk(perr, "R6 perr odd7", perr, 1); do_read();

    // R5 framing: first and second stop low
    send(3'd5, 8'hC3, 0, 2'b01, 0, 3'd5);
    chk(ferr, "R5 stop1", ferr, 1); do_read();
    send(3'd0, 8'h0F, 0, 2'b10, 0, 3'd0);
    chk(ferr, "R5 stop2", ferr, 1); do_read();

    // R4 overrun then recovery
    send(3'd5, 8'h12, 0, 2'b00, 0, 3'd5);
    send(3'd5, 8'h34, 0, 2'b00, 0, 3'd5);
    chk(oerr && data == 8'h34, "R4 overrun", {oerr, data}, {1'b1, 8'h34});
    do_read();
    send(3'd5, 8'h56, 0, 2'b00, 0, 3'd5);
    chk(!oerr, "R4 no overrun", oerr, 0); do_read();

    // R7 glitch rejection: outputs compared every clock stay put
    busy = 1'b0;
    hold_bit(1'b0, 3);
    hold_bit(1'b1, 3 * OVS);
    chk(!rdy, "R7 glitch", rdy, 0);

    // R7 break: one character only, no restart while low
    send(3'd5, 8'h00, 0, 2'b01, 5 * OVS, 3'd5);
    chk(rdy && !oerr && ferr, "R7 break", {rdy, oerr, ferr}, 3'b101);
    do_read();

    // R8 format change mid-frame ignored (sent as 8N1, fmt moved to 7E2)
    send(3'd5, 8'hE7, 0, 2'b00, 0, 3'd0);
    chk(data == 8'hE7 && !ferr && !perr, "R8 fmt latch", data, 8'hE7);
    do_read();

    busy = 1'b1;
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule